// File: doc/BRIEF.md
# Multi-format pixel unpacker

This block sits in a display pixel path and turns each incoming pixel word into the form the colour stage downstream needs. Depending on the configured format, a pixel becomes one of two things. It can become a single palette index, copied to all three channel index outputs. Or it can become three colour components. Those components either pass out directly as an 8-bit RGB triple, or each one serves as the index into its own channel's palette. The per-channel case lets software load a separate correction curve for red, green and blue.

Pixels arrive on two 16-bit ports and on a separate byte-wide legacy input. A wide-path enable selects which input is used. With the enable clear, every legacy byte is a palette index. With it set, a 2-bit depth field chooses 24, 15/16, 8 or 4 bits per pixel. Further controls then select:
- 5-6-5 or 5-5-5 layout;
- the 8-bit sub-format: palette, grey or 3-3-2;
- per-pixel palette escape in 5-5-5;
- a static or pixel-driven choice between the two ports;
- direct or lookup output;
- where a component sits inside its lookup index.

All outputs are registered, with a latency of one clock.

Top module: `pix_unpack`

## Requirements
- R1: While rst_n is low, and after reset until the first valid pixel, out_valid, out_lookup, all three indices and all three colour outputs are zero.
- R2: out_valid equals in_valid from the previous clock. When in_valid is low, every other output keeps its value.
- R3: With cfg_wide_en clear, the pixel is the palette index legacy_byte, whatever the other controls say: out_lookup=1, all three indices equal legacy_byte, and the colour outputs are zero.
- R4: cfg_bpp encodes depth as 0 = 24 bpp, 1 = 15/16 bpp, 2 = 8 bpp and 3 = 4 bpp. At 4 bpp the palette index is port_lo[3:0], zero-extended. At 8 bpp with cfg_sub8 equal to 0 or 3, the palette index is port_lo[7:0].
- R5: At 24 bpp, red is port_hi[7:0], green is port_lo[15:8] and blue is port_lo[7:0].
- R6: At 15/16 bpp the word is split as R=[14:10], G=[9:5], B=[4:0] when cfg_g6 is 0, and as R=[15:11], G=[10:5], B=[4:0] when cfg_g6 is 1.
- R7: With cfg_direct set, out_lookup is 0, the indices are zero, and a component of width w < 8 becomes 8 bits by repeating its own bits from the top down (5 bits c gives {c,c[4:2]}, 6 gives {c,c[5:4]}, 3 gives {c,c,c[2:1]}, 2 gives {c,c,c,c}).
- R8: With cfg_direct clear, every component-split format gives out_lookup=1 and the colour outputs zero, and each component drives its own channel's index.
- R9: In lookup mode, cfg_contig=0 places a component in the top bits of its index with zeros below it. cfg_contig=1 places it in the bottom bits with zeros above it.
- R10: At 15/16 bpp with cfg_g6=0 and cfg_mix15=1, a selected word with bit 15 set is a palette index word[7:0] on all three indices. With bit 15 clear, the word is 5-5-5 colour.
- R11: At 15/16 bpp the word comes from port_hi when cfg_port_hi=1 and from port_lo otherwise. When cfg_port_auto=1 and cfg_g6=0, port_hi[15] makes this choice instead (1 selects port_hi).
- R12: At 8 bpp, cfg_sub8=1 is greyscale, with all three components equal to port_lo[7:0]. cfg_sub8=2 is 3-3-2, with R=[7:5], G=[4:2] and B=[1:0] of port_lo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Pixel present this cycle |
| port_lo | input | 16 | First pixel port |
| port_hi | input | 16 | Second pixel port |
| legacy_byte | input | 8 | Byte-wide legacy pixel input |
| cfg_wide_en | input | 1 | 1: use the pixel ports; 0: legacy byte is a palette index |
| cfg_bpp | input | 2 | Depth: 0=24, 1=15/16, 2=8, 3=4 bpp |
| cfg_g6 | input | 1 | 5-6-5 layout at 15/16 bpp |
| cfg_sub8 | input | 2 | 8 bpp sub-format: 0/3 palette, 1 grey, 2 3-3-2 |
| cfg_mix15 | input | 1 | Bit 15 escapes to palette in 5-5-5 |
| cfg_port_hi | input | 1 | Static selection of port_hi at 15/16 bpp |
| cfg_port_auto | input | 1 | port_hi[15] selects the port in 5-5-5 |
| cfg_direct | input | 1 | 1: direct RGB; 0: per-channel lookup |
| cfg_contig | input | 1 | Lookup index alignment: 0 top, 1 bottom |
| out_valid | output | 1 | Registered pixel valid |
| out_lookup | output | 1 | Indices are meaningful (palette path) |
| out_idx_r | output | 8 | Red channel palette index |
| out_idx_g | output | 8 | Green channel palette index |
| out_idx_b | output | 8 | Blue channel palette index |
| out_r | output | 8 | Direct red |
| out_g | output | 8 | Direct green |
| out_b | output | 8 | Direct blue |

## Verification
Some properties are checked on every cycle:
- the one-clock valid delay and the holding of outputs while idle;
- the rule that the index and colour outputs are never both active;
- the legacy-byte path, the 4 bpp index and the bit-15 palette escape.

Other behaviour is shown only by the bench's directed scenarios, each with computed expected values:
- the exact bit positions of the 5-5-5, 5-6-5, 24-bit, grey and 3-3-2 splits;
- the bit-replication expansion;
- the top and bottom index alignment;
- the port selection driven by a pixel bit.

// File: rtl/pxu_pkg.sv
// Package: shared types and helper functions for the pixel unpacker.
// Assumes components are carried left-aligned in a CW-bit field with their
// true width alongside, so alignment and expansion need only shifts.
package pxu_pkg;

    localparam int CW     = 8;   // component and index width
    localparam int PORT_W = 16;  // width of one pixel port
    localparam int WID_W  = 4;   // width of a component-width field

    typedef enum logic [1:0] {
        BPP_24 = 2'd0,
        BPP_16 = 2'd1,
        BPP_8  = 2'd2,
        BPP_4  = 2'd3
    } bpp_e;

    typedef enum logic [1:0] {
        SUB_PAL  = 2'd0,
        SUB_GREY = 2'd1,
        SUB_332  = 2'd2,
        SUB_RSV  = 2'd3
    } sub8_e;

    // One colour component, MSB-aligned in val, wid bits significant.
    typedef struct packed {
        logic [CW-1:0]    val;
        logic [WID_W-1:0] wid;
    } comp_t;

    // Result of splitting one pixel.
    typedef struct packed {
        logic          pal;      // whole pixel is one palette index
        logic [CW-1:0] pal_idx;  // that index
        comp_t         r;
        comp_t         g;
        comp_t         b;
    } split_t;

    // Fill the low bits of an aligned component by repeating it downwards.
    function automatic logic [CW-1:0] comp_expand(comp_t c);
        logic [CW-1:0] acc;
        acc = c.val;
        for (int k = 1; k < CW / 2; k++) begin
            acc = acc | CW'(c.val >> (k * int'(c.wid)));
        end
        return acc;
    endfunction

    // Place an aligned component at the top (sparse) or bottom of an index.
    function automatic logic [CW-1:0] comp_index(comp_t c, logic contig);
        logic [CW-1:0] res;
        if (contig) begin
            res = CW'(c.val >> (CW - int'(c.wid)));
        end else begin
            res = c.val;
        end
        return res;
    endfunction

endpackage

// File: rtl/pxu_port_mux.sv
// Module: picks the 16-bit word used at 15/16 bpp.
// Assumes the automatic choice applies only to the 5-5-5 layout; otherwise
// the static selection decides.
module pxu_port_mux
    import pxu_pkg::*;
(
    input  logic [PORT_W-1:0] port_lo,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              cfg_port_hi,
    input  logic              cfg_port_auto,
    input  logic              cfg_g6,
    output logic [PORT_W-1:0] word
);

    logic take_hi;

    // Decide which port supplies the word.
    always_comb begin
        if (cfg_port_auto && !cfg_g6) begin
            take_hi = port_hi[PORT_W-1];
        end else begin
            take_hi = cfg_port_hi;
        end
    end

    // Route the chosen port.
    always_comb begin
        word = take_hi ? port_hi : port_lo;
    end

endmodule

// File: rtl/pxu_field_split.sv
// Module: decodes the format controls and splits one pixel into either a
// palette index or three aligned components with their widths.
// Assumes the inputs are stable for the cycle they are sampled.
module pxu_field_split
    import pxu_pkg::*;
(
    input  logic              cfg_wide_en,
    input  logic [1:0]        cfg_bpp,
    input  logic [1:0]        cfg_sub8,
    input  logic              cfg_g6,
    input  logic              cfg_mix15,
    input  logic [CW-1:0]     legacy_byte,
    input  logic [PORT_W-1:0] port_lo,
    input  logic [CW-1:0]     hi_byte,
    input  logic [PORT_W-1:0] word,
    output split_t            split
);

    localparam logic [WID_W-1:0] W8 = WID_W'(8);
    localparam logic [WID_W-1:0] W6 = WID_W'(6);
    localparam logic [WID_W-1:0] W5 = WID_W'(5);
    localparam logic [WID_W-1:0] W3 = WID_W'(3);
    localparam logic [WID_W-1:0] W2 = WID_W'(2);

    logic [CW-1:0] byte8;

    // Low byte of the first port, used by the 8 and 4 bpp formats.
    always_comb begin
        byte8 = port_lo[CW-1:0];
    end

    // Split the pixel according to the active format.
    always_comb begin
        split = '0;
        if (!cfg_wide_en) begin
            split.pal     = 1'b1;
            split.pal_idx = legacy_byte;
        end else begin
            case (bpp_e'(cfg_bpp))
                BPP_4: begin
                    split.pal     = 1'b1;
                    split.pal_idx = {4'b0000, port_lo[3:0]};
                end
                BPP_8: begin
                    case (sub8_e'(cfg_sub8))
                        SUB_GREY: begin
                            split.r = '{val: byte8, wid: W8};
                            split.g = '{val: byte8, wid: W8};
                            split.b = '{val: byte8, wid: W8};
                        end
                        SUB_332: begin
                            split.r = '{val: {byte8[7:5], 5'b0}, wid: W3};
                            split.g = '{val: {byte8[4:2], 5'b0}, wid: W3};
                            split.b = '{val: {byte8[1:0], 6'b0}, wid: W2};
                        end
                        default: begin
                            split.pal     = 1'b1;
                            split.pal_idx = byte8;
                        end
                    endcase
                end
                BPP_16: begin
                    if (!cfg_g6 && cfg_mix15 && word[15]) begin
                        split.pal     = 1'b1;
                        split.pal_idx = word[7:0];
                    end else if (cfg_g6) begin
                        split.r = '{val: {word[15:11], 3'b0}, wid: W5};
                        split.g = '{val: {word[10:5], 2'b0}, wid: W6};
                        split.b = '{val: {word[4:0], 3'b0}, wid: W5};
                    end else begin
                        split.r = '{val: {word[14:10], 3'b0}, wid: W5};
                        split.g = '{val: {word[9:5], 3'b0}, wid: W5};
                        split.b = '{val: {word[4:0], 3'b0}, wid: W5};
                    end
                end
                default: begin
                    split.r = '{val: hi_byte, wid: W8};
                    split.g = '{val: port_lo[15:8], wid: W8};
                    split.b = '{val: port_lo[7:0], wid: W8};
                end
            endcase
        end
    end

endmodule

// File: rtl/pxu_comp_map.sv
// Module: maps one channel to its palette index or its direct 8-bit value.
// Assumes the component arrives MSB-aligned with a width of 2 to 8 bits.
module pxu_comp_map
    import pxu_pkg::*;
(
    input  comp_t         comp,
    input  logic          pal,
    input  logic [CW-1:0] pal_idx,
    input  logic          cfg_direct,
    input  logic          cfg_contig,
    output logic [CW-1:0] idx,
    output logic [CW-1:0] col
);

    // Produce the index or the expanded colour for this channel.
    always_comb begin
        if (pal) begin
            idx = pal_idx;
            col = '0;
        end else if (cfg_direct) begin
            idx = '0;
            col = comp_expand(comp);
        end else begin
            idx = comp_index(comp, cfg_contig);
            col = '0;
        end
    end

endmodule

// File: rtl/pix_unpack.sv
// Module: top of the pixel unpacker. Selects the port, splits the pixel,
// maps each channel and registers the result with one cycle of latency.
// Assumes a synchronous active-low reset and one pixel per clock at most.
module pix_unpack
    import pxu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] port_lo,
    input  logic [PORT_W-1:0] port_hi,
    input  logic [CW-1:0]     legacy_byte,
    input  logic              cfg_wide_en,
    input  logic [1:0]        cfg_bpp,
    input  logic              cfg_g6,
    input  logic [1:0]        cfg_sub8,
    input  logic              cfg_mix15,
    input  logic              cfg_port_hi,
    input  logic              cfg_port_auto,
    input  logic              cfg_direct,
    input  logic              cfg_contig,
    output logic              out_valid,
    output logic              out_lookup,
    output logic [CW-1:0]     out_idx_r,
    output logic [CW-1:0]     out_idx_g,
    output logic [CW-1:0]     out_idx_b,
    output logic [CW-1:0]     out_r,
    output logic [CW-1:0]     out_g,
    output logic [CW-1:0]     out_b
);

    localparam int NCH = 3;

    logic [PORT_W-1:0] word;
    split_t            split;
    comp_t             comps [NCH];
    logic [CW-1:0]     idx_n [NCH];
    logic [CW-1:0]     col_n [NCH];
    logic              lookup_n;

    pxu_port_mux i_mux (
        .port_lo      (port_lo),
        .port_hi      (port_hi),
        .cfg_port_hi  (cfg_port_hi),
        .cfg_port_auto(cfg_port_auto),
        .cfg_g6       (cfg_g6),
        .word         (word)
    );

    pxu_field_split i_split (
        .cfg_wide_en(cfg_wide_en),
        .cfg_bpp    (cfg_bpp),
        .cfg_sub8   (cfg_sub8),
        .cfg_g6     (cfg_g6),
        .cfg_mix15  (cfg_mix15),
        .legacy_byte(legacy_byte),
        .port_lo    (port_lo),
        .hi_byte    (port_hi[CW-1:0]),
        .word       (word),
        .split      (split)
    );

    // Order the split components as red, green, blue.
    always_comb begin
        comps[0] = split.r;
        comps[1] = split.g;
        comps[2] = split.b;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        pxu_comp_map i_map (
            .comp      (comps[ch]),
            .pal       (split.pal),
            .pal_idx   (split.pal_idx),
            .cfg_direct(cfg_direct),
            .cfg_contig(cfg_contig),
            .idx       (idx_n[ch]),
            .col       (col_n[ch])
        );
    end

    // The palette path is used for whole-pixel indices and for lookup mode.
    always_comb begin
        lookup_n = split.pal || !cfg_direct;
    end

    // Track pixel validity one cycle behind the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Capture the mapped pixel, holding the last one when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lookup <= 1'b0;
            out_idx_r  <= '0;
            out_idx_g  <= '0;
            out_idx_b  <= '0;
            out_r      <= '0;
            out_g      <= '0;
            out_b      <= '0;
        end else if (in_valid) begin
            out_lookup <= lookup_n;
            out_idx_r  <= idx_n[0];
            out_idx_g  <= idx_n[1];
            out_idx_b  <= idx_n[2];
            out_r      <= col_n[0];
            out_g      <= col_n[1];
            out_b      <= col_n[2];
        end
    end

endmodule

// File: rtl/pix_unpack_chk.sv
// Module: property checker bound to the pixel unpacker top.
// Assumes it sees the top's ports by name.
module pix_unpack_chk
    import pxu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [PORT_W-1:0] port_lo,
    input logic [PORT_W-1:0] port_hi,
    input logic [CW-1:0]     legacy_byte,
    input logic              cfg_wide_en,
    input logic [1:0]        cfg_bpp,
    input logic              cfg_g6,
    input logic [1:0]        cfg_sub8,
    input logic              cfg_mix15,
    input logic              cfg_port_hi,
    input logic              cfg_port_auto,
    input logic              cfg_direct,
    input logic              cfg_contig,
    input logic              out_valid,
    input logic              out_lookup,
    input logic [CW-1:0]     out_idx_r,
    input logic [CW-1:0]     out_idx_g,
    input logic [CW-1:0]     out_idx_b,
    input logic [CW-1:0]     out_r,
    input logic [CW-1:0]     out_g,
    input logic [CW-1:0]     out_b
);

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: idle input gives no valid and frozen data
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_lookup) && $stable(out_idx_r)
            && $stable(out_idx_g) && $stable(out_idx_b) && $stable(out_r)
            && $stable(out_g) && $stable(out_b));

    assert_legacy_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !cfg_wide_en |=> out_lookup
            && out_idx_r == $past(legacy_byte) && out_idx_g == $past(legacy_byte)
            && out_idx_b == $past(legacy_byte));

    assert_nibble_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cfg_wide_en && cfg_bpp == 2'd3 |=> out_lookup
            && out_idx_r == {4'b0000, $past(port_lo[3:0])});

    assert_lookup_no_colour_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_lookup |-> out_r == '0 && out_g == '0 && out_b == '0);

    assert_direct_no_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_lookup |-> out_idx_r == '0 && out_idx_g == '0
            && out_idx_b == '0);

    assert_msb_escape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cfg_wide_en && cfg_bpp == 2'd1 && !cfg_g6 && cfg_mix15
            && !cfg_port_auto && !cfg_port_hi && port_lo[15]
            |=> out_lookup && out_idx_g == $past(port_lo[7:0]));

    // Controls that only shape data are not constrained here.
    logic unused_ok;
    always_comb begin
        unused_ok = ^{port_hi, cfg_sub8, cfg_direct, cfg_contig};
    end

endmodule

bind pix_unpack pix_unpack_chk i_chk (.*);

// File: tb/test_pix_unpack.sv
`timescale 1ns/1ps
module test_pix_unpack;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] port_lo, port_hi;
    logic [7:0]  legacy_byte;
    logic        cfg_wide_en, cfg_g6, cfg_mix15, cfg_port_hi, cfg_port_auto;
    logic        cfg_direct, cfg_contig;
    logic [1:0]  cfg_bpp, cfg_sub8;
    logic        out_valid, out_lookup;
    logic [7:0]  out_idx_r, out_idx_g, out_idx_b, out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pix_unpack i_pix_unpack (.*);

    // Reference expansions by width
    function automatic logic [7:0] e5(logic [4:0] c); return {c, c[4:2]}; endfunction
    function automatic logic [7:0] e6(logic [5:0] c); return {c, c[5:4]}; endfunction
    function automatic logic [7:0] e3(logic [2:0] c); return {c, c, c[2:1]}; endfunction
    function automatic logic [7:0] e2(logic [1:0] c); return {c, c, c, c}; endfunction

    task automatic check(string tag, logic v, logic lk, logic [7:0] ir, logic [7:0] ig,
                         logic [7:0] ib, logic [7:0] r, logic [7:0] g, logic [7:0] b);
        logic [49:0] act, exp;
        act = {out_valid, out_lookup, out_idx_r, out_idx_g, out_idx_b, out_r, out_g, out_b};
        exp = {v, lk, ir, ig, ib, r, g, b};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_default();
        cfg_wide_en = 1'b1; cfg_bpp = 2'd0; cfg_g6 = 1'b0; cfg_sub8 = 2'd0;
        cfg_mix15 = 1'b0; cfg_port_hi = 1'b0; cfg_port_auto = 1'b0;
        cfg_direct = 1'b1; cfg_contig = 1'b0;
    endtask

    task automatic drive(logic [15:0] lo, logic [15:0] hi, logic [7:0] leg);
        @(negedge clk);
        in_valid = 1'b1; port_lo = lo; port_hi = hi; legacy_byte = leg;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; port_lo = 16'hFFFF; port_hi = 16'hFFFF;
        legacy_byte = 8'hFF; cfg_default();
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 after reset", 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_legacy();
        cfg_default(); cfg_wide_en = 1'b0; cfg_bpp = 2'd0; cfg_direct = 1'b1;
        drive(16'h1234, 16'h5678, 8'h5A);
        check("R3 legacy index", 1, 1, 8'h5A, 8'h5A, 8'h5A, 0, 0, 0);
    endtask

    task automatic t_hold();
        @(negedge clk);
        port_lo = 16'h0F0F; legacy_byte = 8'hC3;
        @(posedge clk);
        #1;
        check("R2 idle hold", 0, 1, 8'h5A, 8'h5A, 8'h5A, 0, 0, 0);
    endtask

    task automatic t_depth_index();
        cfg_default(); cfg_bpp = 2'd3;
        drive(16'hFFF7, 16'h0000, 8'h00);
        check("R4 4bpp index", 1, 1, 8'h07, 8'h07, 8'h07, 0, 0, 0);
        cfg_bpp = 2'd2; cfg_sub8 = 2'd0;
        drive(16'h12E4, 16'h0000, 8'h00);
        check("R4 8bpp index", 1, 1, 8'hE4, 8'hE4, 8'hE4, 0, 0, 0);
        cfg_sub8 = 2'd3;
        drive(16'h0033, 16'h0000, 8'h00);
        check("R4 8bpp reserved index", 1, 1, 8'h33, 8'h33, 8'h33, 0, 0, 0);
    endtask

    task automatic t_true24();
        cfg_default(); cfg_bpp = 2'd0;
        drive(16'hB2C3, 16'h77A1, 8'h00);
        check("R5 24bpp direct", 1, 0, 0, 0, 0, 8'hA1, 8'hB2, 8'hC3);
        cfg_direct = 1'b0;
        drive(16'hB2C3, 16'h77A1, 8'h00);
        check("R5 R8 24bpp lookup", 1, 1, 8'hA1, 8'hB2, 8'hC3, 0, 0, 0);
    endtask

    task automatic t_hicolor();
        logic [15:0] p;
        cfg_default(); cfg_bpp = 2'd1;
        p = 16'h54D9;
        drive(p, 16'h0000, 8'h00);
        check("R6 R7 555 direct", 1, 0, 0, 0, 0, e5(p[14:10]), e5(p[9:5]), e5(p[4:0]));
        cfg_g6 = 1'b1; p = 16'hA5C3;
        drive(p, 16'h0000, 8'h00);
        check("R6 R7 565 direct", 1, 0, 0, 0, 0, e5(p[15:11]), e6(p[10:5]), e5(p[4:0]));
    endtask

    task automatic t_align();
        logic [15:0] p;
        cfg_default(); cfg_bpp = 2'd1; cfg_direct = 1'b0; p = 16'h54D9;
        drive(p, 16'h0000, 8'h00);
        check("R9 R8 555 top aligned", 1, 1, {p[14:10], 3'b0}, {p[9:5], 3'b0},
              {p[4:0], 3'b0}, 0, 0, 0);
        cfg_contig = 1'b1;
        drive(p, 16'h0000, 8'h00);
        check("R9 555 bottom aligned", 1, 1, {3'b0, p[14:10]}, {3'b0, p[9:5]},
              {3'b0, p[4:0]}, 0, 0, 0);
        cfg_g6 = 1'b1; p = 16'hA5C3;
        drive(p, 16'h0000, 8'h00);
        check("R9 565 bottom aligned", 1, 1, {3'b0, p[15:11]}, {2'b0, p[10:5]},
              {3'b0, p[4:0]}, 0, 0, 0);
        cfg_contig = 1'b0;
        drive(p, 16'h0000, 8'h00);
        check("R9 565 top aligned", 1, 1, {p[15:11], 3'b0}, {p[10:5], 2'b0},
              {p[4:0], 3'b0}, 0, 0, 0);
    endtask

    task automatic t_escape();
        logic [15:0] p;
        cfg_default(); cfg_bpp = 2'd1; cfg_mix15 = 1'b1; p = 16'h8042;
        drive(p, 16'h0000, 8'h00);
        check("R10 bit15 palette", 1, 1, 8'h42, 8'h42, 8'h42, 0, 0, 0);
        p = 16'h0042;
        drive(p, 16'h0000, 8'h00);
        check("R10 bit15 clear colour", 1, 0, 0, 0, 0, e5(p[14:10]), e5(p[9:5]), e5(p[4:0]));
        cfg_mix15 = 1'b0; p = 16'h8042;
        drive(p, 16'h0000, 8'h00);
        check("R10 escape off", 1, 0, 0, 0, 0, e5(p[14:10]), e5(p[9:5]), e5(p[4:0]));
    endtask

    task automatic t_ports();
        logic [15:0] lo, hi;
        cfg_default(); cfg_bpp = 2'd1; cfg_port_auto = 1'b1;
        lo = 16'h1234; hi = 16'h9ABC;
        drive(lo, hi, 8'h00);
        check("R11 auto picks hi", 1, 0, 0, 0, 0, e5(hi[14:10]), e5(hi[9:5]), e5(hi[4:0]));
        hi = 16'h1ABC;
        drive(lo, hi, 8'h00);
        check("R11 auto picks lo", 1, 0, 0, 0, 0, e5(lo[14:10]), e5(lo[9:5]), e5(lo[4:0]));
        cfg_port_auto = 1'b0; cfg_port_hi = 1'b1;
        drive(lo, hi, 8'h00);
        check("R11 static hi", 1, 0, 0, 0, 0, e5(hi[14:10]), e5(hi[9:5]), e5(hi[4:0]));
        cfg_port_auto = 1'b1; cfg_g6 = 1'b1; cfg_port_hi = 1'b0; hi = 16'hF0F0;
        drive(lo, hi, 8'h00);
        check("R11 565 ignores auto", 1, 0, 0, 0, 0, e5(lo[15:11]), e6(lo[10:5]), e5(lo[4:0]));
    endtask

    task automatic t_byte_formats();
        logic [7:0] v;
        cfg_default(); cfg_bpp = 2'd2; cfg_sub8 = 2'd1; v = 8'h6B;
        drive({8'hFF, v}, 16'h0000, 8'h00);
        check("R12 grey direct", 1, 0, 0, 0, 0, v, v, v);
        cfg_sub8 = 2'd2; v = 8'hAE;
        drive({8'h00, v}, 16'h0000, 8'h00);
        check("R12 R7 332 direct", 1, 0, 0, 0, 0, e3(v[7:5]), e3(v[4:2]), e2(v[1:0]));
        cfg_direct = 1'b0;
        drive({8'h00, v}, 16'h0000, 8'h00);
        check("R12 R9 332 top", 1, 1, {v[7:5], 5'b0}, {v[4:2], 5'b0}, {v[1:0], 6'b0}, 0, 0, 0);
        cfg_contig = 1'b1;
        drive({8'h00, v}, 16'h0000, 8'h00);
        check("R12 R9 332 bottom", 1, 1, {5'b0, v[7:5]}, {5'b0, v[4:2]}, {6'b0, v[1:0]}, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_legacy();
        t_hold();
        t_depth_index();
        t_true24();
        t_hicolor();
        t_align();
        t_escape();
        t_ports();
        t_byte_formats();
        repeat (2) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule